// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Masking Controller

This block routes level-sensitive device interrupt lines to two CPUs through two masking stages. A source must first be enabled at the shared enable stage, then unmasked in the bank of the target CPU, before it can raise that CPU's IRQ or FIQ line. Enable and mask changes are made by writing an interrupt number to a set or clear register, not a bitmask. Each source also has a routing register that sets or clears its IRQ and FIQ unmask bits for every CPU in one write.

A small register bus carries an accessing-CPU identifier with every request. The per-CPU window is one address range, and each access to it is steered to the bank of the CPU that issued it. The low-numbered sources are private per-CPU sources, so each CPU keeps its own enable copy of them. Source 0 of each CPU is that CPU's doorbell summary, gated by a doorbell mask register in its bank. A cause register in the window reports the lowest-numbered active source of the accessing CPU.

The bus front end is a two-state machine: ST_IDLE and ST_RESP. The transition ST_IDLE→ST_RESP fires on an accepted read. ST_RESP→ST_RESP fires on a back-to-back read. ST_RESP→ST_IDLE and ST_IDLE→ST_IDLE fire on any cycle with no read. Writes take effect in the cycle they are presented, in either state.

Top module: `imic_top`

## Requirements
- R1: After reset, every source is disabled and masked for every CPU, both doorbell masks read 0, all IRQ/FIQ outputs are low, and routing registers read 0.
- R2: A shared source (index 29..NUM_SRC-1) raises CPU c's IRQ only when it is pending, enabled, and IRQ-unmasked for c. Writing index i to word address 0x000 enables source i. Writing it to 0x001 disables it.
- R3: In the per-CPU window, writing index i to 0x040 clears both the IRQ and FIQ unmask bits of source i for the accessing CPU. Writing i to 0x041 sets its IRQ unmask bit for that CPU only.
- R4: The routing register of source i is at word address 0x100+i. Bit c is the IRQ unmask of CPU c and bit 8+c is its FIQ unmask, and the other bits read 0. It shares its state with the R3 operations, so either path is visible through the other.
- R5: CPU c's FIQ is the OR of its pending, enabled sources whose FIQ unmask bit is set. IRQ unmask bits do not affect FIQ.
- R6: For sources 0..28, the enable writes of R2 change only the accessing CPU's private enable copy.
- R7: Source 0 is pending for CPU c when any bit of c's doorbell cause input ANDed with c's doorbell mask is 1. The doorbell mask is read/write at window address 0x042 and is banked per CPU.
- R8: A read of window address 0x043 returns bit 31 = 1 and bits [7:0] = the lowest-numbered source that is pending, enabled and unmasked (IRQ or FIQ) for the accessing CPU. It returns 0 when no source is active.
- R9: A set or clear write whose index is NUM_SRC or more changes no state and no output.
- R10: Outputs are registered. A level change on a source line appears on the outputs after one clock edge, and a register write appears one edge after the write edge.
- R11: A read request returns its data with rvalid high in the next cycle. Unmapped addresses read 0, and rvalid is low in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | NUM_SRC | Level interrupt lines. Bit 0 is unused, because source 0 is the doorbell summary |
| db_cause | input | NUM_CPU*DB_W | Doorbell cause bits, DB_W per CPU |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Identifier of the accessing CPU |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data, or an interrupt index for set/clear registers |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_o | output | NUM_CPU | IRQ line of each CPU |
| fiq_o | output | NUM_CPU | FIQ line of each CPU |

## Verification
On every cycle the assertions check the gating itself. A CPU line never rises in the cycle after its enable or unmask vector was all zero. An out-of-range enable write leaves the shared enables stable. A read is answered in exactly the following cycle. Only the bench scenarios can show the remaining behaviour. That covers index-addressed updates reaching the right bit, banked window steering, the shared state between routing registers and set/clear masks, the private enable copies of per-CPU sources, doorbell gating, and cause priority.

// File: rtl/imic_pkg.sv
package imic_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_GSET  = 10'h000;
    localparam logic [ADDR_W-1:0] A_GCLR  = 10'h001;
    localparam logic [ADDR_W-1:0] A_MSET  = 10'h040;
    localparam logic [ADDR_W-1:0] A_MCLR  = 10'h041;
    localparam logic [ADDR_W-1:0] A_DBM   = 10'h042;
    localparam logic [ADDR_W-1:0] A_CAUSE = 10'h043;
    localparam logic [1:0]        A_SCTL_HI = 2'b01;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_GSET,
        OP_GCLR,
        OP_MSET,
        OP_MCLR,
        OP_DBW,
        OP_SCW
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [2:0]        cpu;
        logic [7:0]        idx;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_st_e;
endpackage

// File: rtl/imic_bus_fsm.sv
module imic_bus_fsm
    import imic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int CPU_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] rd_word,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    bus_st_e           state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_req;
    logic              idx_ok;
    logic              sctl_hit;
    logic              sctl_ok;

    assign rd_req   = bus_valid && !bus_write;
    assign idx_ok   = bus_wdata < DATA_W'(NUM_SRC);
    assign sctl_hit = bus_addr[ADDR_W-1:8] == A_SCTL_HI;
    assign sctl_ok  = {24'b0, bus_addr[7:0]} < DATA_W'(NUM_SRC);

    // write decode: applied at the same edge as the request
    always_comb begin
        cmd      = '0;
        cmd.op   = OP_NONE;
        cmd.cpu  = 3'(bus_cpu);
        cmd.data = bus_wdata;
        cmd.idx  = sctl_hit ? bus_addr[7:0] : bus_wdata[7:0];
        if (bus_valid && bus_write) begin
            if (sctl_hit) begin
                if (sctl_ok) cmd.op = OP_SCW;
            end else begin
                unique case (bus_addr)
                    A_GSET:  if (idx_ok) cmd.op = OP_GSET;
                    A_GCLR:  if (idx_ok) cmd.op = OP_GCLR;
                    A_MSET:  if (idx_ok) cmd.op = OP_MSET;
                    A_MCLR:  if (idx_ok) cmd.op = OP_MCLR;
                    A_DBM:   cmd.op = OP_DBW;
                    default: cmd.op = OP_NONE;
                endcase
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_word;
    end

    // outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
        endcase
    end
endmodule

// File: rtl/imic_glb_en.sv
module imic_glb_en
    import imic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PCPU = 29
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  cmd_t                        cmd,
    output logic [NUM_SRC-NUM_PCPU-1:0] glb_en
);
    localparam int G_N  = NUM_SRC - NUM_PCPU;
    localparam int GI_W = (G_N > 1) ? $clog2(G_N) : 1;

    logic [7:0]      gi_full;
    logic [GI_W-1:0] gi;
    logic            shared_hit;

    assign shared_hit = cmd.idx >= 8'(NUM_PCPU);
    assign gi_full    = cmd.idx - 8'(NUM_PCPU);
    assign gi         = gi_full[GI_W-1:0];

    wire unused_glb = ^{cmd.cpu, cmd.data, gi_full};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= '0;
        end else if (shared_hit) begin
            if (cmd.op == OP_GSET)      glb_en[gi] <= 1'b1;
            else if (cmd.op == OP_GCLR) glb_en[gi] <= 1'b0;
        end
    end
endmodule

// File: rtl/imic_cpu_bank.sv
module imic_cpu_bank
    import imic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PCPU = 29,
    parameter int DB_W     = 32,
    parameter int CPU_ID   = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cmd_t                cmd,
    output logic [NUM_PCPU-1:0] pcpu_en,
    output logic [NUM_SRC-1:0]  irq_um,
    output logic [NUM_SRC-1:0]  fiq_um,
    output logic [DB_W-1:0]     db_mask
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int PI_W  = $clog2(NUM_PCPU);

    logic             mine;
    logic             priv_hit;
    logic [IDX_W-1:0] si;
    logic [PI_W-1:0]  pi;

    assign mine     = cmd.cpu == 3'(CPU_ID);
    assign priv_hit = cmd.idx < 8'(NUM_PCPU);
    assign si       = cmd.idx[IDX_W-1:0];
    assign pi       = cmd.idx[PI_W-1:0];

    wire unused_bank = ^{cmd.data, cmd.idx};

    // private enable copy for the per-CPU sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcpu_en <= '0;
        end else if (mine && priv_hit) begin
            if (cmd.op == OP_GSET)      pcpu_en[pi] <= 1'b1;
            else if (cmd.op == OP_GCLR) pcpu_en[pi] <= 1'b0;
        end
    end

    // unmask state: the routing register and the set/clear window share it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_um <= '0;
            fiq_um <= '0;
        end else begin
            unique case (cmd.op)
                OP_MSET: if (mine) begin
                    irq_um[si] <= 1'b0;
                    fiq_um[si] <= 1'b0;
                end
                OP_MCLR: if (mine) irq_um[si] <= 1'b1;
                OP_SCW: begin
                    irq_um[si] <= cmd.data[CPU_ID];
                    fiq_um[si] <= cmd.data[8+CPU_ID];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          db_mask <= '0;
        else if (mine && cmd.op == OP_DBW)   db_mask <= cmd.data[DB_W-1:0];
    end
endmodule

// File: rtl/imic_out_stage.sv
module imic_out_stage
    import imic_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] irq_um,
    input  logic [NUM_SRC-1:0] fiq_um,
    output logic               irq_q,
    output logic               fiq_q,
    output logic [DATA_W-1:0]  cause
);
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] act;
    logic               c_valid;
    logic [7:0]         c_idx;

    assign live = pend & en;
    assign act  = live & (irq_um | fiq_um);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |(live & irq_um);
            fiq_q <= |(live & fiq_um);
        end
    end

    // lowest index wins
    always_comb begin
        c_valid = 1'b0;
        c_idx   = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (act[s]) begin
                c_valid = 1'b1;
                c_idx   = 8'(s);
            end
        end
    end

    assign cause = {c_valid, 23'b0, c_idx};
endmodule

// File: rtl/imic_top.sv
module imic_top
    import imic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PCPU = 29,
    parameter int NUM_CPU  = 2,
    parameter int DB_W     = 32,
    parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_line,
    input  logic [NUM_CPU*DB_W-1:0] db_cause,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [CPU_W-1:0]        bus_cpu,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    output logic [NUM_CPU-1:0]      irq_o,
    output logic [NUM_CPU-1:0]      fiq_o
);
    localparam int G_N   = NUM_SRC - NUM_PCPU;
    localparam int IDX_W = $clog2(NUM_SRC);

    cmd_t                       cmd;
    logic [DATA_W-1:0]          rd_word;
    logic [G_N-1:0]             glb_en;
    logic [NUM_PCPU-1:0]        pcpu_en [NUM_CPU];
    logic [NUM_SRC-1:0]         irq_um  [NUM_CPU];
    logic [NUM_SRC-1:0]         fiq_um  [NUM_CPU];
    logic [DB_W-1:0]            db_mask [NUM_CPU];
    logic [DATA_W-1:0]          cause   [NUM_CPU];
    logic [NUM_SRC-1:0]         en      [NUM_CPU];
    logic [NUM_SRC-1:0]         pend    [NUM_CPU];
    logic [NUM_CPU*NUM_SRC-1:0] en_all;
    logic [NUM_CPU*NUM_SRC-1:0] irq_um_all;
    logic [NUM_CPU*NUM_SRC-1:0] fiq_um_all;

    wire unused_line0 = src_line[0];

    imic_bus_fsm #(.NUM_SRC(NUM_SRC), .CPU_W(CPU_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_cpu    (bus_cpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_word    (rd_word),
        .cmd        (cmd),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    imic_glb_en #(.NUM_SRC(NUM_SRC), .NUM_PCPU(NUM_PCPU)) u_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .glb_en (glb_en)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        imic_cpu_bank #(
            .NUM_SRC  (NUM_SRC),
            .NUM_PCPU (NUM_PCPU),
            .DB_W     (DB_W),
            .CPU_ID   (c)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .pcpu_en (pcpu_en[c]),
            .irq_um  (irq_um[c]),
            .fiq_um  (fiq_um[c]),
            .db_mask (db_mask[c])
        );

        assign pend[c] = {src_line[NUM_SRC-1:1],
                          |(db_cause[c*DB_W +: DB_W] & db_mask[c])};
        assign en[c]   = {glb_en, pcpu_en[c]};

        assign en_all    [c*NUM_SRC +: NUM_SRC] = en[c];
        assign irq_um_all[c*NUM_SRC +: NUM_SRC] = irq_um[c];
        assign fiq_um_all[c*NUM_SRC +: NUM_SRC] = fiq_um[c];

        imic_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend   (pend[c]),
            .en     (en[c]),
            .irq_um (irq_um[c]),
            .fiq_um (fiq_um[c]),
            .irq_q  (irq_o[c]),
            .fiq_q  (fiq_o[c]),
            .cause  (cause[c])
        );
    end

    // read mux, steered by the accessing CPU
    logic             sctl_hit;
    logic             sctl_ok;
    logic [IDX_W-1:0] sidx;

    assign sctl_hit = bus_addr[ADDR_W-1:8] == A_SCTL_HI;
    assign sctl_ok  = {24'b0, bus_addr[7:0]} < DATA_W'(NUM_SRC);
    assign sidx     = bus_addr[IDX_W-1:0];

    always_comb begin
        rd_word = '0;
        if (sctl_hit) begin
            if (sctl_ok) begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    rd_word[c]   = irq_um[c][sidx];
                    rd_word[8+c] = fiq_um[c][sidx];
                end
            end
        end else if (bus_addr == A_DBM) begin
            rd_word = DATA_W'(db_mask[bus_cpu]);
        end else if (bus_addr == A_CAUSE) begin
            rd_word = cause[bus_cpu];
        end
    end
endmodule

// File: rtl/imic_chk.sv
module imic_chk
    import imic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_PCPU = 29,
    parameter int NUM_CPU  = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_valid,
    input logic                         bus_write,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         bus_rvalid,
    input logic [NUM_CPU-1:0]           irq_o,
    input logic [NUM_CPU-1:0]           fiq_o,
    input logic [NUM_SRC-NUM_PCPU-1:0]  glb_en,
    input logic [NUM_CPU*NUM_SRC-1:0]   en_all,
    input logic [NUM_CPU*NUM_SRC-1:0]   irq_um_all,
    input logic [NUM_CPU*NUM_SRC-1:0]   fiq_um_all
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        p_gate_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_all[c*NUM_SRC +: NUM_SRC] == '0) |-> !irq_o[c] && !fiq_o[c]);

        p_irq_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(irq_um_all[c*NUM_SRC +: NUM_SRC] == '0) |-> !irq_o[c]);

        p_fiq_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(fiq_um_all[c*NUM_SRC +: NUM_SRC] == '0) |-> !fiq_o[c]);
    end

    p_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_addr == A_GSET || bus_addr == A_GCLR)
         && bus_wdata >= DATA_W'(NUM_SRC)) |=> $stable(glb_en));

    p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    p_no_spurious_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind imic_top imic_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_PCPU (NUM_PCPU),
    .NUM_CPU  (NUM_CPU)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .glb_en     (glb_en),
    .en_all     (en_all),
    .irq_um_all (irq_um_all),
    .fiq_um_all (fiq_um_all)
);

// File: tb/imic_top_tb.sv
module imic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_line = '0;
    logic [63:0] db_cause = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  irq_o;
    logic [1:0]  fiq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] rd_cap = '0;

    typedef struct {
        string       req;
        logic [31:0] exp;
        bit          rd;
    } item_t;
    item_t sb[$];
    item_t cur;

    always #5 clk = ~clk;

    imic_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_line   (src_line),
        .db_cause   (db_cause),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_cpu    (bus_cpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares queued expectations against the design
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            check(cur.req, cur.rd ? rd_cap : {28'b0, fiq_o, irq_o}, cur.exp);
        end
    end

    task automatic wr(input bit cpu, input logic [9:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = cpu;
        bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // expected outputs encoded as {fiq[1:0], irq[1:0]}
    task automatic exp_out(input string req, input logic [3:0] exp);
        @(negedge clk);
        @(negedge clk);
        sb.push_back('{req, {28'b0, exp}, 1'b0});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic exp_rd(input string req, input bit cpu, input logic [9:0] addr,
                          input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = cpu; bus_addr = addr;
        @(negedge clk);
        bus_valid = 1'b0;
        rd_cap = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
        sb.push_back('{req, exp, 1'b1});
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_out("R1 outputs after reset", 4'b0000);
        exp_rd("R1 doorbell mask cpu0", 1'b0, 10'h042, 32'h0);
        exp_rd("R1 routing src40", 1'b0, 10'h100 + 10'd40, 32'h0);

        // R2 two-level gating on a shared source
        src_line[40] = 1'b1;
        exp_out("R2 pending only", 4'b0000);
        wr(1'b0, 10'h000, 40);
        exp_out("R2 enabled but masked", 4'b0000);
        wr(1'b0, 10'h041, 40);
        exp_out("R3 unmask cpu0 only", 4'b0001);
        wr(1'b0, 10'h001, 40);
        exp_out("R2 disabled globally", 4'b0000);
        wr(1'b0, 10'h000, 40);
        exp_out("R2 re-enabled", 4'b0001);

        // R4/R5 routing register
        wr(1'b1, 10'h100 + 10'd40, 32'h0000_0202);
        exp_out("R5 routed irq+fiq to cpu1", 4'b1010);
        exp_rd("R4 routing readback", 1'b0, 10'h100 + 10'd40, 32'h0000_0202);
        wr(1'b1, 10'h040, 40);
        exp_out("R3 mask from cpu1", 4'b0000);
        exp_rd("R4 routing sees window mask", 1'b1, 10'h100 + 10'd40, 32'h0);

        wr(1'b0, 10'h041, 40);
        exp_out("R3 cpu0 unmask again", 4'b0001);
        exp_rd("R8 cause cpu0", 1'b0, 10'h043, 32'h8000_0028);
        exp_rd("R8 cause cpu1 none", 1'b1, 10'h043, 32'h0);

        // R9 out-of-range indices
        wr(1'b0, 10'h001, 64);
        exp_out("R9 clear-enable idx 64 ignored", 4'b0001);
        wr(1'b0, 10'h040, 100);
        exp_out("R9 set-mask idx 100 ignored", 4'b0001);

        // R10 level following
        src_line[40] = 1'b0;
        exp_out("R10 line drop", 4'b0000);

        // R6 private enable copies
        src_line[5] = 1'b1;
        wr(1'b0, 10'h000, 5);
        wr(1'b0, 10'h041, 5);
        exp_out("R6 per-cpu src cpu0", 4'b0001);
        wr(1'b1, 10'h041, 5);
        exp_out("R6 cpu1 copy still disabled", 4'b0001);
        wr(1'b1, 10'h000, 5);
        exp_out("R6 cpu1 enabled", 4'b0011);
        wr(1'b0, 10'h001, 5);
        exp_out("R6 cpu0 disable leaves cpu1", 4'b0010);
        exp_rd("R8 cause cpu1 src5", 1'b1, 10'h043, 32'h8000_0005);

        // R7 doorbell gating
        db_cause[3] = 1'b1;
        wr(1'b0, 10'h000, 0);
        wr(1'b0, 10'h041, 0);
        exp_out("R7 doorbell masked", 4'b0010);
        wr(1'b0, 10'h042, 32'h0000_0008);
        exp_out("R7 doorbell unmasked", 4'b0011);
        exp_rd("R7 banked mask cpu1", 1'b1, 10'h042, 32'h0);
        exp_rd("R7 banked mask cpu0", 1'b0, 10'h042, 32'h8);
        exp_rd("R8 cause cpu0 src0", 1'b0, 10'h043, 32'h8000_0000);

        // R10 registered output: no change before the next edge
        @(negedge clk);
        src_line[5] = 1'b0;
        #1;
        check("R10 not combinational", {28'b0, fiq_o, irq_o}, 32'h3);
        @(posedge clk);
        #1;
        check("R10 one edge later", {28'b0, fiq_o, irq_o}, 32'h1);

        // R11 unmapped read
        exp_rd("R11 unmapped reads zero", 1'b0, 10'h3FF, 32'h0);

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule